// File: doc/BRIEF.md
# Byte-Select External Memory Write Interface

This block writes single bytes into a 16-bit-wide external memory over a bus that carries both address and data on the same 16 lines. A byte write request brings a 21-bit byte pointer and an 8-bit value. The block then runs a fixed four-cycle bus sequence. First it places the word address on the shared lines and pulses the address latch enable. It then switches the lines to data and pulses a single write strobe.

The byte value is copied onto both halves of the data bus. The memory stores only the half that the lane outputs select. Two styles of memory are served at once. Memories that use per-byte enables get two active-low lane enables, one for the upper byte and one for the lower byte. Memories that take a byte address line get the pointer's least significant bit on a dedicated output.

The word address is the pointer without its bit 0. Its low 16 bits travel on the shared bus. The remaining upper bits go on separate upper-address lines, which are enabled only when the wide-address mode input is set at request time.

Top module: `bsel_wr_if`

## Requirements
- R1: Out of reset and whenever no sequence runs, the shared bus is released (`ad_oe_o` = 0), `ale_o` = 0, `busy_o` = 0, and `wrh_n_o`, `ub_n_o` and `lb_n_o` are 1.
- R2: In the first cycle after a request is accepted, `ale_o` = 1, `ad_oe_o` = 1 and `ad_o` carries pointer bits [16:1].
- R3: In the second cycle, `ale_o` = 0 and `ad_o` = {byte, byte}, the byte on both halves.
- R4: `wrh_n_o` is 0 in the third cycle only. In the fourth cycle `wrh_n_o` is back at 1 and `ad_o` still holds {byte, byte}.
- R5: `wrl_n_o` and `oe_n_o` are 1 at all times.
- R6: During a sequence, pointer bit 0 = 1 gives `ub_n_o` = 0 and `lb_n_o` = 1, and bit 0 = 0 gives the reverse. A memory honouring these enables stores the byte in bits [15:8] or [7:0] of the word respectively.
- R7: During a sequence, `ba0_o` equals pointer bit 0. It is 0 when idle.
- R8: With `wide_addr_i` = 1 at request time, `addr_hi_oe_o` = 1 and `addr_hi_o` = pointer bits [20:17] for the whole sequence. Otherwise both are 0.
- R9: `busy_o` is 1 for exactly four cycles per sequence. A request made while busy is ignored: it leaves the running sequence unchanged and starts no new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req_i | input | 1 | Byte write request, accepted when idle |
| ptr_i | input | 21 | Byte pointer |
| wdata_i | input | 8 | Byte to write |
| wide_addr_i | input | 1 | Enable upper address lines for this write |
| busy_o | output | 1 | Sequence in progress |
| ad_o | output | 16 | Shared address/data bus value |
| ad_oe_o | output | 1 | Shared bus drive enable |
| addr_hi_o | output | 4 | Upper word-address lines |
| addr_hi_oe_o | output | 1 | Upper address drive enable |
| ale_o | output | 1 | Address latch enable, active high |
| wrh_n_o | output | 1 | Write strobe, active low |
| wrl_n_o | output | 1 | Unused low write strobe, held high |
| oe_n_o | output | 1 | Read output enable, held high |
| ub_n_o | output | 1 | Upper byte enable, active low |
| lb_n_o | output | 1 | Lower byte enable, active low |
| ba0_o | output | 1 | Byte address line |

## Verification
The bench builds the block with its default widths: a 21-bit pointer, a 16-bit shared bus and four upper address lines. It sweeps the low six pointer bits through all 64 values. This covers both lanes of 32 distinct words, so each word ends up holding two bytes that were written separately. The upper pointer bits and the wide-address mode vary with the sweep index. A request injected during the second bus cycle of every eighth write tests that busy requests are ignored. A behavioural 16-bit memory driven only by the bus pins is compared against an arithmetic model of the expected contents.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_STRB,
    PH_HOLD
  } phase_t;
endpackage

// File: rtl/bsw_seq.sv
module bsw_seq
  import bsw_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_i,
  output logic   accept_o,
  output phase_t phase_q_o,
  output phase_t phase_d_o
);
  phase_t phase_q, phase_d;

  assign accept_o = req_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (req_i) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_DATA;
      PH_DATA: phase_d = PH_STRB;
      PH_STRB: phase_d = PH_HOLD;
      PH_HOLD: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;

  // R9: a request seen mid-sequence never restarts the address phase
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && phase_q != PH_HOLD && req_i) |=> (phase_q != PH_ADDR));

  // R4: the strobe phase is always followed by the hold phase
  p_strb_to_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STRB) |=> (phase_q == PH_HOLD));
endmodule

// File: rtl/bsw_lane.sv
module bsw_lane (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic active_d_i,
  input  logic lsb_i,
  output logic ub_n_o,
  output logic lb_n_o,
  output logic ba0_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ub_n_o <= 1'b1;
      lb_n_o <= 1'b1;
      ba0_o  <= 1'b0;
    end else if (load_i) begin
      ub_n_o <= ~lsb_i;
      lb_n_o <= lsb_i;
      ba0_o  <= lsb_i;
    end else if (!active_d_i) begin
      ub_n_o <= 1'b1;
      lb_n_o <= 1'b1;
      ba0_o  <= 1'b0;
    end
  end

  // R7: the byte address line only rises together with an upper-lane enable
  p_ba0_upper_r7: assert property (@(posedge clk) disable iff (rst)
    ba0_o |-> (!ub_n_o && lb_n_o));
endmodule

// File: rtl/bsel_wr_if.sv
module bsel_wr_if
  import bsw_pkg::*;
#(
  parameter int PTR_W = 21,
  parameter int AD_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_req_i,
  input  logic [PTR_W-1:0]          ptr_i,
  input  logic [AD_W/2-1:0]         wdata_i,
  input  logic                      wide_addr_i,
  output logic                      busy_o,
  output logic [AD_W-1:0]           ad_o,
  output logic                      ad_oe_o,
  output logic [PTR_W-AD_W-2:0]     addr_hi_o,
  output logic                      addr_hi_oe_o,
  output logic                      ale_o,
  output logic                      wrh_n_o,
  output logic                      wrl_n_o,
  output logic                      oe_n_o,
  output logic                      ub_n_o,
  output logic                      lb_n_o,
  output logic                      ba0_o
);
  localparam int BYTE_W = AD_W / 2;
  localparam int LANES  = AD_W / BYTE_W;
  localparam int HI_W   = PTR_W - 1 - AD_W;

  logic   accept;
  phase_t phase_q, phase_d;

  bsw_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_i     (wr_req_i),
    .accept_o  (accept),
    .phase_q_o (phase_q),
    .phase_d_o (phase_d)
  );

  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] dat_q;
  logic              wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      dat_q  <= '0;
      wide_q <= 1'b0;
    end else if (accept) begin
      ptr_q  <= ptr_i;
      dat_q  <= wdata_i;
      wide_q <= wide_addr_i;
    end
  end

  logic [PTR_W-1:0]  cur_ptr;
  logic [BYTE_W-1:0] cur_dat;
  logic              cur_wide;
  assign cur_ptr  = accept ? ptr_i       : ptr_q;
  assign cur_dat  = accept ? wdata_i     : dat_q;
  assign cur_wide = accept ? wide_addr_i : wide_q;

  logic [AD_W-1:0] dup;
  for (genvar k = 0; k < LANES; k++) begin : g_dup
    assign dup[k*BYTE_W +: BYTE_W] = cur_dat;
  end

  bsw_lane u_lane (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .active_d_i (phase_d != PH_IDLE),
    .lsb_i      (ptr_i[0]),
    .ub_n_o     (ub_n_o),
    .lb_n_o     (lb_n_o),
    .ba0_o      (ba0_o)
  );

  logic            busy_q, ale_q, ad_oe_q, wrh_n_q, hi_oe_q;
  logic [AD_W-1:0] ad_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ale_q   <= 1'b0;
      ad_oe_q <= 1'b0;
      wrh_n_q <= 1'b1;
      ad_q    <= '0;
      hi_q    <= '0;
      hi_oe_q <= 1'b0;
    end else begin
      busy_q  <= (phase_d != PH_IDLE);
      ale_q   <= (phase_d == PH_ADDR);
      ad_oe_q <= (phase_d != PH_IDLE);
      wrh_n_q <= (phase_d != PH_STRB);
      case (phase_d)
        PH_ADDR:                   ad_q <= cur_ptr[AD_W:1];
        PH_DATA, PH_STRB, PH_HOLD: ad_q <= dup;
        default:                   ad_q <= '0;
      endcase
      if ((phase_d != PH_IDLE) && cur_wide) begin
        hi_oe_q <= 1'b1;
        hi_q    <= cur_ptr[PTR_W-1:AD_W+1];
      end else begin
        hi_oe_q <= 1'b0;
        hi_q    <= '0;
      end
    end
  end

  assign busy_o       = busy_q;
  assign ale_o        = ale_q;
  assign ad_oe_o      = ad_oe_q;
  assign ad_o         = ad_q;
  assign wrh_n_o      = wrh_n_q;
  assign addr_hi_o    = hi_q;
  assign addr_hi_oe_o = hi_oe_q;
  assign wrl_n_o      = 1'b1;
  assign oe_n_o       = 1'b1;

  // R1: idle means a released bus and all enables inactive
  p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!ad_oe_q && !ale_q && wrh_n_q && ub_n_o && lb_n_o));

  // R3: the address phase lasts one cycle and is followed by driven data
  p_ale_next_r3: assert property (@(posedge clk) disable iff (rst)
    ale_q |=> (!ale_q && ad_oe_q && busy_q));

  // R4: the write strobe is a single-cycle pulse
  p_strobe_one_r4: assert property (@(posedge clk) disable iff (rst)
    !wrh_n_q |=> wrh_n_q);

  // R4: data stays on the bus across the strobe release
  p_hold_data_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wrh_n_q) |-> ($stable(ad_q) && busy_q));

  // R6: exactly one lane enable is active while busy, matching the byte line
  p_lanes_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((ub_n_o != lb_n_o) && (ba0_o == !ub_n_o)));
endmodule

// File: tb/tb_bsel_wr_if.sv
module tb_bsel_wr_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_req = 1'b0;
  logic [20:0] ptr = '0;
  logic [7:0]  wdata = '0;
  logic        wide = 1'b0;
  logic        busy, ad_oe, hi_oe, ale, wrh_n, wrl_n, oe_n, ub_n, lb_n, ba0;
  logic [15:0] ad;
  logic [3:0]  hi;

  always #10 clk = ~clk;

  bsel_wr_if dut (
    .clk(clk), .rst(rst), .wr_req_i(wr_req), .ptr_i(ptr), .wdata_i(wdata),
    .wide_addr_i(wide), .busy_o(busy), .ad_o(ad), .ad_oe_o(ad_oe),
    .addr_hi_o(hi), .addr_hi_oe_o(hi_oe), .ale_o(ale), .wrh_n_o(wrh_n),
    .wrl_n_o(wrl_n), .oe_n_o(oe_n), .ub_n_o(ub_n), .lb_n_o(lb_n), .ba0_o(ba0)
  );

  // behavioural 16-bit memory driven only by bus pins
  logic [15:0] stub_mem [256];
  logic [15:0] exp_mem  [256];
  logic [7:0]  stub_idx;
  logic        stub_wrh_prev;
  initial begin
    for (int i = 0; i < 256; i++) begin
      stub_mem[i] = '0;
      exp_mem[i]  = '0;
    end
    stub_idx = '0;
    stub_wrh_prev = 1'b1;
  end
  always @(negedge clk) begin
    if (ale) stub_idx <= ad[7:0];
    if (wrh_n && !stub_wrh_prev) begin
      if (!ub_n) stub_mem[stub_idx][15:8] <= ad[15:8];
      if (!lb_n) stub_mem[stub_idx][7:0]  <= ad[7:0];
    end
    stub_wrh_prev <= wrh_n;
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_idle(input string rq);
    chk(!busy && !ad_oe && !ale, rq, {busy, ad_oe, ale}, 3'b000);
    chk(wrh_n && ub_n && lb_n && !ba0, rq, {wrh_n, ub_n, lb_n, ba0}, 4'b1110);
    chk(wrl_n && oe_n, "R5", {wrl_n, oe_n}, 2'b11);
  endtask

  task automatic do_write(input logic [20:0] p, input logic [7:0] d, input bit w, input bit inject);
    logic [15:0] dd;
    dd = {d, d};
    @(negedge clk);
    wr_req = 1'b1; ptr = p; wdata = d; wide = w;
    @(negedge clk);
    // cycle 1: address phase
    chk(ale && ad_oe, "R2", {ale, ad_oe}, 2'b11);
    chk(ad == p[16:1], "R2", ad, p[16:1]);
    chk(busy, "R9", busy, 1);
    chk(ub_n == !p[0] && lb_n == p[0], "R6", {ub_n, lb_n}, {!p[0], p[0]});
    chk(ba0 == p[0], "R7", ba0, p[0]);
    chk(hi_oe == w && hi == (w ? p[20:17] : 4'h0), "R8", {hi_oe, hi}, {w, (w ? p[20:17] : 4'h0)});
    wr_req = 1'b0;
    @(negedge clk);
    // cycle 2: data phase
    chk(!ale && ad == dd && wrh_n, "R3", {ale, wrh_n, ad}, {2'b01, dd});
    if (inject) begin
      wr_req = 1'b1; ptr = p ^ 21'h1F_FFFF; wdata = ~d; wide = !w;
    end
    @(negedge clk);
    // cycle 3: strobe
    chk(!wrh_n && ad == dd, "R4", {wrh_n, ad}, {1'b0, dd});
    chk(wrl_n && oe_n, "R5", {wrl_n, oe_n}, 2'b11);
    chk(ub_n == !p[0] && ba0 == p[0], "R9", {ub_n, ba0}, {!p[0], p[0]});
    chk(hi_oe == w, "R8", hi_oe, w);
    wr_req = 1'b0;
    @(negedge clk);
    // cycle 4: hold
    chk(wrh_n && ad == dd && busy, "R4", {busy, wrh_n, ad}, {2'b11, dd});
    @(negedge clk);
    chk_idle("R1");
    chk(!busy, "R9", busy, 0);
    if (p[0]) exp_mem[p[8:1]][15:8] = d;
    else      exp_mem[p[8:1]][7:0]  = d;
    chk(stub_mem[p[8:1]] == exp_mem[p[8:1]], "R6", stub_mem[p[8:1]], exp_mem[p[8:1]]);
    if (inject) begin
      @(negedge clk);
      chk(!busy && !ale, "R9", {busy, ale}, 2'b00);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    chk(!hi_oe && hi == 4'h0, "R8", {hi_oe, hi}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    for (int p = 0; p < 64; p++) begin
      logic [20:0] pp;
      logic [7:0]  pd;
      pp = {4'(p ^ 10), 8'(p * 3), 3'b000, 6'(p)};
      pd = 8'(p * 29 + 5);
      do_write(pp, pd, (p % 3) != 0, (p % 8) == 5);
    end
    for (int i = 0; i < 32; i++)
      chk(stub_mem[i] == exp_mem[i], "R6", stub_mem[i], exp_mem[i]);
    chk_idle("R1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule